// File: doc/BRIEF.md
# Burst Address Counter

This block produces the address that a synchronous memory port uses for each access. At every rising clock edge it does one of four things: it takes a fresh address from the external address bus, steps the address it last used up by one, keeps that address, or clears it to zero. It is meant for burst traffic, where a host gives one start address and then lets the port walk through the following locations without driving the bus again.

All three controls are active low. Clear wins over load, load wins over step, and hold is what remains. Nothing else gates the counter: it has no chip-select or byte-select input, so a step request is honoured even while the port is deselected. The address is registered. The value on the output during a cycle is the one the array uses for that cycle's access. A clear produces a real access to address 0 in the same cycle, so it costs no idle cycle.

Top module: `burst_addr_ctr`

## Requirements
- R1: While the synchronous active-high `rst` is 1 at a rising edge, `curAddr` is 0 after that edge.
- R2: When `loadN` is 0 and `clearN` is 1 at an edge, `curAddr` equals the `extAddr` value sampled at that edge, starting one edge later. That value becomes the base for later steps.
- R3: When `clearN` and `loadN` are 1 and `countN` is 0 at an edge, `curAddr` after the edge is its previous value plus one.
- R4: When `clearN`, `loadN` and `countN` are all 1 at an edge, `curAddr` keeps its value and `extAddr` has no effect on it.
- R5: When `clearN` is 0 at an edge, `curAddr` becomes 0, whatever `loadN`, `countN` and `extAddr` are.
- R6: When `loadN` and `countN` are both 0 and `clearN` is 1, the external address is taken and no step is added.
- R7: Stepping from the all-ones address gives 0.
- R8: A clear or a load is followed by no idle cycle. A step on the very next edge gives 1 after a clear, or base+1 after a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| extAddr | input | ADDR_W | External start address |
| loadN | input | 1 | Address strobe, active low: take `extAddr` |
| countN | input | 1 | Count enable, active low: step by one |
| clearN | input | 1 | Counter clear, active low: go to address 0 |
| curAddr | output | ADDR_W | Address used by the current access |

## Verification
Each control is first driven alone: a load, a run of steps, and a run of holds while `extAddr` changes. These show that each action has its own effect and a latency of one edge. Next, the controls are asserted together in every pairing (clear with load and step, load with step). This shows the priority order as distinct from a merge of actions. Boundary runs load the all-ones address and step once, and step on the edge right after a clear or a load, to show the wrap and the absence of an idle cycle. Last, a long random mix of all controls is checked against a model built from the priority rules.

// File: rtl/addr_ctr_pkg.sv
package addr_ctr_pkg;

  // One-hot action request from the decoder to the counter register.
  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } ctrStrobes_t;

endpackage

// File: rtl/addr_ctr_ctrl.sv
module addr_ctr_ctrl
  import addr_ctr_pkg::*;
(
  input  logic        clearN,
  input  logic        loadN,
  input  logic        countN,
  output ctrStrobes_t strobes
);

  // Fixed priority: clear, then load, then step; no request means hold.
  always_comb begin
    strobes = '0;
    if (!clearN)      strobes.clear = 1'b1;
    else if (!loadN)  strobes.load  = 1'b1;
    else if (!countN) strobes.step  = 1'b1;
  end

endmodule

// File: rtl/addr_ctr_path.sv
module addr_ctr_path
  import addr_ctr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrStrobes_t       strobes,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr
);

  localparam logic [ADDR_W-1:0] ADDR_ZERO = '0;
  localparam logic [ADDR_W-1:0] ADDR_INC  = ADDR_W'(1);

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] addrNext;
  logic [ADDR_W-1:0] addrPlusOne;

  // Modulo-2^ADDR_W increment: all-ones rolls over to zero (R7).
  assign addrPlusOne = addrReg + ADDR_INC;

  always_comb begin
    addrNext = addrReg;
    if (strobes.clear)     addrNext = ADDR_ZERO;
    else if (strobes.load) addrNext = extAddr;
    else if (strobes.step) addrNext = addrPlusOne;
  end

  always_ff @(posedge clk) begin
    if (rst) addrReg <= ADDR_ZERO;
    else     addrReg <= addrNext;
  end

  assign curAddr = addrReg;

  // The decoder must never request two actions at once (R6 priority).
  p_one_action_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import addr_ctr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              loadN,
  input  logic              countN,
  input  logic              clearN,
  output logic [ADDR_W-1:0] curAddr
);

  localparam logic [ADDR_W-1:0] ONE_STEP = ADDR_W'(1);

  ctrStrobes_t strobes;

  addr_ctr_ctrl i_ctrl (
    .clearN  (clearN),
    .loadN   (loadN),
    .countN  (countN),
    .strobes (strobes)
  );

  addr_ctr_path #(.ADDR_W(ADDR_W)) i_path (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .extAddr (extAddr),
    .curAddr (curAddr)
  );

  // Port-level checks of the action rules.
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !clearN |=> (curAddr == '0));

  p_load_taken_r2: assert property (@(posedge clk) disable iff (rst)
    (clearN && !loadN) |=> (curAddr == $past(extAddr)));

  p_step_plus_one_r3: assert property (@(posedge clk) disable iff (rst)
    (clearN && loadN && !countN) |=> (curAddr == $past(curAddr) + ONE_STEP));

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (clearN && loadN && countN) |=> $stable(curAddr));

  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (clearN && loadN && !countN && (curAddr == '1)) |=> (curAddr == '0));

endmodule

// File: tb/test_burst_addr_ctr.sv
module test_burst_addr_ctr;

  localparam int ADDR_W = 13;
  localparam logic [ADDR_W-1:0] ALL_ONES = '1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] extAddr = '0;
  logic              loadN = 1'b1;
  logic              countN = 1'b1;
  logic              clearN = 1'b1;
  logic [ADDR_W-1:0] curAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [ADDR_W-1:0] model = '0;

  always #2 clk = ~clk;

  burst_addr_ctr #(.ADDR_W(ADDR_W)) i_burst_addr_ctr (
    .clk     (clk),
    .rst     (rst),
    .extAddr (extAddr),
    .loadN   (loadN),
    .countN  (countN),
    .clearN  (clearN),
    .curAddr (curAddr)
  );

  task automatic check(string req, logic [ADDR_W-1:0] expected);
    checks++;
    if (curAddr !== expected) begin
      failures++;
      $display("FAIL %s: curAddr=%0h expected=%0h", req, curAddr, expected);
    end
  endtask

  // Drive one cycle, update the model from the priority rules, check after the edge.
  task automatic cyc(logic c, logic l, logic n, logic [ADDR_W-1:0] a, string req);
    @(negedge clk);
    clearN = c; loadN = l; countN = n; extAddr = a;
    @(posedge clk);
    if (!c)      model = '0;
    else if (!l) model = a;
    else if (!n) model = model + 1'b1;
    #1;
    check(req, model);
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    rst = 1'b1; clearN = 1'b1; loadN = 1'b0; countN = 1'b0; extAddr = 13'h0abc;
    @(posedge clk); #1;
    model = '0;
    check("R1", '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_load_r2();
    cyc(1, 0, 1, 13'h1234, "R2");
    cyc(1, 0, 1, 13'h0007, "R2");
  endtask

  task automatic t_step_r3();
    cyc(1, 0, 1, 13'h0100, "R3");
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 13'h1fff, "R3");
    check("R3", 13'h0105);
  endtask

  task automatic t_hold_r4();
    cyc(1, 0, 1, 13'h0555, "R4");
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 13'(i * 13'h0333), "R4");
    check("R4", 13'h0555);
  endtask

  task automatic t_clear_r5();
    cyc(1, 0, 1, 13'h0aaa, "R5");
    cyc(0, 0, 0, 13'h1111, "R5");
    check("R5", '0);
    cyc(1, 0, 1, 13'h0aaa, "R5");
    cyc(0, 1, 1, 13'h1111, "R5");
    cyc(0, 1, 0, 13'h0000, "R5");
  endtask

  task automatic t_priority_r6();
    cyc(1, 0, 1, 13'h0200, "R6");
    cyc(1, 0, 0, 13'h0300, "R6");
    check("R6", 13'h0300);
  endtask

  task automatic t_wrap_r7();
    cyc(1, 0, 1, ALL_ONES, "R7");
    cyc(1, 1, 0, 13'h0000, "R7");
    check("R7", '0);
    cyc(1, 1, 0, 13'h0000, "R7");
  endtask

  task automatic t_no_gap_r8();
    cyc(1, 0, 1, 13'h0777, "R8");
    cyc(0, 1, 1, 13'h0000, "R8");
    cyc(1, 1, 0, 13'h0000, "R8");
    check("R8", 13'h0001);
    cyc(1, 0, 1, 13'h0040, "R8");
    cyc(1, 1, 0, 13'h0000, "R8");
    check("R8", 13'h0041);
  endtask

  task automatic t_random_mix();
    for (int i = 0; i < 400; i++) begin
      logic [2:0] ctl;
      ctl = 3'($urandom_range(0, 7));
      cyc((ctl != 0), ctl[1] | (ctl == 0), ctl[2] & ctl[0],
          13'($urandom()), "R2 R3 R4 R5 R6 mix");
    end
  endtask

  initial begin
    t_reset_r1();
    t_load_r2();
    t_step_r3();
    t_hold_r4();
    t_clear_r5();
    t_priority_r6();
    t_wrap_r7();
    t_no_gap_r8();
    t_random_mix();
    t_reset_r1();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule